// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This block is a 32-bit integer datapath that carries out one saturating operation per cycle, chosen by a 4-bit opcode. It covers these operations:

- signed and unsigned add and subtract with clamping;
- a signed doubling that clamps;
- an add that wraps but still reports signed overflow;
- clamping of a signed or unsigned value to a programmable bit width, both on the whole word and on its two 16-bit halves independently.

Each accepted operation produces a registered result one clock later. Any operation that clamps, or that overflows in the case of the wrapping add, sets a sticky saturation flag. The flag stays set until a dedicated clear input or reset lowers it.

The unit sits beside an integer pipeline. The pipeline presents operands, an opcode and a width field together with a valid strobe. It consumes the result on the following cycle. At a convenient point it inspects and clears the sticky flag to learn whether any value in a sequence was clipped.

Top module: `sat_alu`

## Requirements
- R1: Opcode 0 (signed add) returns A+B. If A and B have equal sign bits and the sum's sign differs from A, the result is 0x7FFFFFFF when A is non-negative and 0x80000000 when A is negative, and the flag is set.
- R2: Opcode 1 (signed subtract) returns A-B. If A and B have different sign bits and the difference's sign differs from A, the result clamps as in R1 and the flag is set.
- R3: Opcode 2 (reporting add) always returns the wrapped 32-bit sum A+B. It sets the flag under exactly the overflow condition of R1.
- R4: Opcode 3 (signed doubling of A) behaves as follows. When A as signed is at least 0x40000000, it returns 0x7FFFFFFF and sets the flag. When A is at most 0xC0000000 as signed, it returns 0x80000000 and sets the flag. Otherwise it returns A shifted left by one.
- R5: Opcode 4 (unsigned add) returns 0xFFFFFFFF and sets the flag when the unsigned sum exceeds 32 bits. Otherwise it returns A+B.
- R6: Opcode 5 (unsigned subtract) returns 0 and sets the flag when B is greater than A (unsigned). Otherwise it returns A-B.
- R7: Opcode 6 (signed width clamp of A with n = width field, 0..31) behaves as follows. If A (signed) is above 2^n-1, it returns 2^n-1. If A is below -2^n, it returns the bitwise inverse of 2^n-1. Either case sets the flag; otherwise A passes unchanged.
- R8: Opcode 7 (unsigned width clamp of A with n) returns 0 when A is negative as signed and 2^n-1 when A exceeds 2^n-1. Either case sets the flag; otherwise A passes unchanged.
- R9: Opcode 8 applies the R7 clamp with the same n to A[15:0] and to A[31:16], each taken as a signed 16-bit value. It places the low 16 bits of each result back in its own half. The flag is set if either half clamps.
- R10: Opcode 9 applies the R8 clamp to each signed 16-bit half of A in the same way as R9.
- R11: The flag is set on the edge after a valid cycle whose operation saturates. It stays set on later edges unless the clear input is high. A clear with no saturating valid operation in the same cycle lowers it. A saturating operation in the same cycle as a clear leaves it set.
- R12: On the edge after in_valid is high, the result and res_valid update. While in_valid is low, res_valid is low, the result holds, and the flag is not set.
- R13: Synchronous reset drives result 0, res_valid 0 and flag 0.
- R14: Opcodes 10 to 15 return 0 and never set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted this cycle |
| op | input | 4 | Operation select |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| width | input | 5 | Bit width n for the width clamps |
| q_clear | input | 1 | Clears the sticky flag |
| res | output | 32 | Registered result |
| res_valid | output | 1 | Result updated on the last edge |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
The embedded assertions watch several behaviours on every cycle:

- the flag's set, hold and clear rules;
- the one-cycle relation between in_valid and res_valid;
- the holding of the result while idle;
- the zero result of unused opcodes;
- the zero clamp of unsigned subtract.

The clamp values for every other opcode, the exact doubling thresholds and the per-half packing depend on the arithmetic of the operands. The bench shows these through its model, using boundary operands 0x7FFFFFFF, 0x80000000, 0x40000000, 0xC0000000 and 0xFFFFFFFF and several widths, followed by seeded random operations with occasional clears.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int unsigned SAT_OP_W = 4;

  typedef enum logic [SAT_OP_W-1:0] {
    OP_SADD   = 4'd0,
    OP_SSUB   = 4'd1,
    OP_ADDV   = 4'd2,
    OP_SDBL   = 4'd3,
    OP_UADD   = 4'd4,
    OP_USUB   = 4'd5,
    OP_SSATW  = 4'd6,
    OP_USATW  = 4'd7,
    OP_SSAT16 = 4'd8,
    OP_USAT16 = 4'd9
  } sat_op_e;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sadd_res,
  output logic         sadd_q,
  output logic [W-1:0] ssub_res,
  output logic         ssub_q,
  output logic [W-1:0] addv_res,
  output logic         addv_q,
  output logic [W-1:0] uadd_res,
  output logic         uadd_q,
  output logic [W-1:0] usub_res,
  output logic         usub_q
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0]   wide_sum;
  logic [W-1:0] sum;
  logic [W-1:0] diff;
  logic [W-1:0] clamp_val;

  assign wide_sum  = {1'b0, a} + {1'b0, b};
  assign sum       = wide_sum[W-1:0];
  assign diff      = a - b;
  // clamp direction follows the sign of A
  assign clamp_val = a[W-1] ? SMIN : SMAX;

  assign sadd_q   = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
  assign sadd_res = sadd_q ? clamp_val : sum;

  assign ssub_q   = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
  assign ssub_res = ssub_q ? clamp_val : diff;

  assign addv_q   = sadd_q;
  assign addv_res = sum;

  assign uadd_q   = wide_sum[W];
  assign uadd_res = uadd_q ? {W{1'b1}} : sum;

  assign usub_q   = b > a;
  assign usub_res = usub_q ? {W{1'b0}} : diff;
endmodule

// File: rtl/sat_double.sv
module sat_double #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] res,
  output logic         sat
);
  localparam logic [W-1:0] HI_LIM = {2'b01, {(W-2){1'b0}}};
  localparam logic [W-1:0] LO_LIM = {2'b11, {(W-2){1'b0}}};
  localparam logic [W-1:0] SMAX   = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN   = {1'b1, {(W-1){1'b0}}};

  logic pos_hit;
  logic neg_hit;

  assign pos_hit = $signed(a) >= $signed(HI_LIM);
  assign neg_hit = $signed(a) <= $signed(LO_LIM);
  assign sat     = pos_hit | neg_hit;

  always_comb begin
    if (pos_hit)      res = SMAX;
    else if (neg_hit) res = SMIN;
    else              res = {a[W-2:0], 1'b0};
  end
endmodule

// File: rtl/sat_width.sv
module sat_width #(
  parameter int W   = 32,
  parameter int SHW = 5
) (
  input  logic [W-1:0]   val,
  input  logic [SHW-1:0] n,
  input  logic           is_uns,
  output logic [W-1:0]   res,
  output logic           sat
);
  logic [W-1:0] lim;
  logic [W-1:0] top;
  logic         top_pos;
  logic         top_low;

  assign lim     = (W'(1) << n) - W'(1);
  assign top     = W'($signed(val) >>> n);
  assign top_pos = !top[W-1] && (top != '0);
  assign top_low = top[W-1] && (top != '1);

  always_comb begin
    res = val;
    sat = 1'b0;
    if (is_uns) begin
      if (val[W-1]) begin
        res = '0;
        sat = 1'b1;
      end else if (val > lim) begin
        res = lim;
        sat = 1'b1;
      end
    end else begin
      if (top_pos) begin
        res = lim;
        sat = 1'b1;
      end else if (top_low) begin
        res = ~lim;
        sat = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [$clog2(DATA_W)-1:0] width,
  input  logic              q_clear,
  output logic [DATA_W-1:0] res,
  output logic              res_valid,
  output logic              q_flag
);
  import sat_pkg::*;

  localparam int SHW    = $clog2(DATA_W);
  localparam int HALF_W = DATA_W / 2;
  localparam int LANES  = 2;

  sat_op_e op_sel;
  assign op_sel = sat_op_e'(op);

  logic [DATA_W-1:0] sadd_res, ssub_res, addv_res, uadd_res, usub_res, dbl_res;
  logic              sadd_q, ssub_q, addv_q, uadd_q, usub_q, dbl_q;

  sat_addsub #(.W(DATA_W)) u_addsub (
    .a(opa), .b(opb),
    .sadd_res(sadd_res), .sadd_q(sadd_q),
    .ssub_res(ssub_res), .ssub_q(ssub_q),
    .addv_res(addv_res), .addv_q(addv_q),
    .uadd_res(uadd_res), .uadd_q(uadd_q),
    .usub_res(usub_res), .usub_q(usub_q)
  );

  sat_double #(.W(DATA_W)) u_double (
    .a(opa), .res(dbl_res), .sat(dbl_q)
  );

  // full-word clamp; mode picked by opcode
  logic              word_uns;
  logic [DATA_W-1:0] word_res;
  logic              word_q;
  assign word_uns = (op_sel == OP_USATW);

  sat_width #(.W(DATA_W), .SHW(SHW)) u_word (
    .val(opa), .n(width), .is_uns(word_uns), .res(word_res), .sat(word_q)
  );

  // per-half clamps computed in lane width
  logic              half_uns;
  logic [DATA_W-1:0] half_res;
  logic [LANES-1:0]  half_q;
  assign half_uns = (op_sel == OP_USAT16);

  for (genvar g = 0; g < LANES; g++) begin : g_half
    sat_width #(.W(HALF_W), .SHW(SHW)) u_lane (
      .val   (opa[g*HALF_W +: HALF_W]),
      .n     (width),
      .is_uns(half_uns),
      .res   (half_res[g*HALF_W +: HALF_W]),
      .sat   (half_q[g])
    );
  end

  logic [DATA_W-1:0] nxt_res;
  logic              nxt_q;

  always_comb begin
    nxt_res = '0;
    nxt_q   = 1'b0;
    case (op_sel)
      OP_SADD:   begin nxt_res = sadd_res; nxt_q = sadd_q;  end
      OP_SSUB:   begin nxt_res = ssub_res; nxt_q = ssub_q;  end
      OP_ADDV:   begin nxt_res = addv_res; nxt_q = addv_q;  end
      OP_SDBL:   begin nxt_res = dbl_res;  nxt_q = dbl_q;   end
      OP_UADD:   begin nxt_res = uadd_res; nxt_q = uadd_q;  end
      OP_USUB:   begin nxt_res = usub_res; nxt_q = usub_q;  end
      OP_SSATW,
      OP_USATW:  begin nxt_res = word_res; nxt_q = word_q;  end
      OP_SSAT16,
      OP_USAT16: begin nxt_res = half_res; nxt_q = |half_q; end
      default:   begin nxt_res = '0;       nxt_q = 1'b0;    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      res_valid <= 1'b0;
      q_flag    <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res <= nxt_res;
      q_flag <= (q_flag & ~q_clear) | (in_valid & nxt_q);
    end
  end

  // R11: flag holds unless cleared
  assert_q_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (q_flag && !q_clear) |=> q_flag);
  // R11: saturating valid operation sets the flag, even against a clear
  assert_q_set_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && nxt_q) |=> q_flag);
  // R11: clear with no saturating event lowers the flag
  assert_q_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (q_clear && !(in_valid && nxt_q)) |=> !q_flag);
  // R12: valid strobe is echoed one cycle later
  assert_valid_echo_R12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  // R12: idle cycles keep the result and raise no valid
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && $stable(res)));
  // R14: unused opcodes give zero
  assert_unused_zero_R14: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op > 4'd9) |=> (res == '0));
  // R6: unsigned subtract with B above A clamps to zero
  assert_usub_floor_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd5 && opb > opa) |=> (res == '0 && q_flag));
endmodule

// File: tb/test_sat_alu.sv
module test_sat_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [4:0]  width = '0;
  logic        q_clear = 1'b0;
  logic [31:0] res;
  logic        res_valid;
  logic        q_flag;

  int checks = 0;
  int errors = 0;
  logic eq = 1'b0;

  always #4 clk = ~clk;

  sat_alu #(.DATA_W(32)) i_sat_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
    .width(width), .q_clear(q_clear), .res(res), .res_valid(res_valid),
    .q_flag(q_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      4'd9: return "R10";
      default: return "R14";
    endcase
  endfunction

  // signed clamp to range [-2^n, 2^n-1]; returns {flag, value}
  function automatic logic [32:0] clamp_s(input longint v, input int n);
    longint hi = (longint'(1) <<< n) - 1;
    longint lo = -(longint'(1) <<< n);
    if (v > hi) return {1'b1, 32'(hi)};
    if (v < lo) return {1'b1, 32'(lo)};
    return {1'b0, 32'(v)};
  endfunction

  function automatic logic [32:0] clamp_u(input longint v, input int n);
    longint hi = (longint'(1) <<< n) - 1;
    if (v < 0)  return {1'b1, 32'd0};
    if (v > hi) return {1'b1, 32'(hi)};
    return {1'b0, 32'(v)};
  endfunction

  function automatic logic [32:0] model(input logic [3:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input logic [4:0] n);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ua = longint'({32'd0, a});
    longint ub = longint'({32'd0, b});
    longint smax = 64'sd2147483647;
    longint smin = -64'sd2147483648;
    longint s;
    logic [32:0] lo_r, hi_r;
    case (o)
      4'd0, 4'd1: begin
        s = (o == 4'd0) ? sa + sb : sa - sb;
        if (s > smax) return {1'b1, 32'h7FFFFFFF};
        if (s < smin) return {1'b1, 32'h80000000};
        return {1'b0, 32'(s)};
      end
      4'd2: begin
        s = sa + sb;
        return {(s > smax) || (s < smin), a + b};
      end
      4'd3: begin
        if (sa >= 64'sh40000000) return {1'b1, 32'h7FFFFFFF};
        if (sa <= -64'sh40000000) return {1'b1, 32'h80000000};
        return {1'b0, a << 1};
      end
      4'd4: begin
        s = ua + ub;
        if (s > 64'hFFFFFFFF) return {1'b1, 32'hFFFFFFFF};
        return {1'b0, 32'(s)};
      end
      4'd5: begin
        if (ub > ua) return {1'b1, 32'd0};
        return {1'b0, a - b};
      end
      4'd6: return clamp_s(sa, int'(n));
      4'd7: return clamp_u(sa, int'(n));
      4'd8, 4'd9: begin
        if (o == 4'd8) begin
          lo_r = clamp_s(longint'($signed(a[15:0])), int'(n));
          hi_r = clamp_s(longint'($signed(a[31:16])), int'(n));
        end else begin
          lo_r = clamp_u(longint'($signed(a[15:0])), int'(n));
          hi_r = clamp_u(longint'($signed(a[31:16])), int'(n));
        end
        return {lo_r[32] | hi_r[32], hi_r[15:0], lo_r[15:0]};
      end
      default: return {1'b0, 32'd0};
    endcase
  endfunction

  task automatic do_op(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] n, input bit clr);
    logic [32:0] e;
    @(negedge clk);
    op = o; opa = a; opb = b; width = n; in_valid = 1'b1; q_clear = clr;
    @(negedge clk);
    in_valid = 1'b0; q_clear = 1'b0;
    e  = model(o, a, b, n);
    eq = (clr ? 1'b0 : eq) | e[32];
    chk(res == e[31:0], tag(o), res, e[31:0]);
    chk(q_flag == eq, "R11 flag", {31'd0, q_flag}, {31'd0, eq});
    chk(res_valid == 1'b1, "R12 valid", {31'd0, res_valid}, 32'd1);
  endtask

  logic [31:0] corners [7] = '{32'h7FFFFFFF, 32'h80000000, 32'h40000000,
                               32'hC0000000, 32'hFFFFFFFF, 32'h00000000, 32'h00000001};
  logic [4:0]  widths [5]  = '{5'd0, 5'd7, 5'd15, 5'd16, 5'd31};

  initial begin : watchdog
    #1200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] held;
    int seed;
    seed = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(res == '0, "R13 res", res, 32'd0);
    chk(res_valid == 1'b0, "R13 valid", {31'd0, res_valid}, 32'd0);
    chk(q_flag == 1'b0, "R13 flag", {31'd0, q_flag}, 32'd0);
    rst = 1'b0;

    // directed boundary sweep, clear with each op so flag equals this op's event
    for (int o = 0; o < 10; o++)
      for (int i = 0; i < 7; i++)
        for (int j = 0; j < 7; j++)
          do_op(4'(o), corners[i], corners[j], widths[(i + j) % 5], 1'b1);

    // directed halfword and width specifics (R9, R10, R7, R8)
    do_op(4'd8, 32'h7FFF8000, 32'd0, 5'd7, 1'b1);
    do_op(4'd9, 32'h8000007F, 32'd0, 5'd7, 1'b1);
    do_op(4'd9, 32'h01230045, 32'd0, 5'd16, 1'b1);
    do_op(4'd6, 32'hFFFFFF80, 32'd0, 5'd7, 1'b1);
    do_op(4'd7, 32'h00000100, 32'd0, 5'd8, 1'b1);

    // R12: idle cycles keep result and drop valid, no flag change
    do_op(4'd0, 32'd5, 32'd6, 5'd0, 1'b1);
    held = res;
    repeat (3) @(negedge clk);
    chk(res == held, "R12 hold", res, held);
    chk(res_valid == 1'b0, "R12 idle valid", {31'd0, res_valid}, 32'd0);
    chk(q_flag == 1'b0, "R12 idle flag", {31'd0, q_flag}, 32'd0);

    // R11: set then hold across idle and non-saturating ops, then clear alone
    do_op(4'd4, 32'hFFFFFFFF, 32'd1, 5'd0, 1'b0);
    do_op(4'd0, 32'd1, 32'd1, 5'd0, 1'b0);
    repeat (2) @(negedge clk);
    chk(q_flag == 1'b1, "R11 sticky", {31'd0, q_flag}, 32'd1);
    q_clear = 1'b1;
    @(negedge clk);
    q_clear = 1'b0;
    eq = 1'b0;
    chk(q_flag == 1'b0, "R11 clear", {31'd0, q_flag}, 32'd0);

    // R14: unused opcodes
    for (int o = 10; o < 16; o++)
      do_op(4'(o), 32'h80000000, 32'h7FFFFFFF, 5'd3, 1'b0);

    // seeded random traffic with boundary mixing and occasional clears
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] a, b;
      a = ($urandom % 4 == 0) ? corners[$urandom % 7] : $urandom;
      b = ($urandom % 4 == 0) ? corners[$urandom % 7] : $urandom;
      do_op(4'($urandom % 11), a, b, 5'($urandom), ($urandom % 8) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule